// File: doc/BRIEF.md
# Prioritized 64-Source Interrupt Controller

This block collects 64 level-sensitive interrupt requests and, on every clock, selects the one request that should reach the processor. Each source has a hardware pending bit, a mask bit, a software force bit, an enable bit and an 8-bit priority byte. A source takes part in the selection when it is pending or forced, enabled and not masked. Among those, the source with the largest priority byte wins, and a tie goes to the higher source number.

The winner is presented as a 3-bit interrupt level and an 8-bit vector number. Software programs the controller over a simple 32-bit register bus that spans a 256-byte address window. The bus has combinational reads and writes that take effect at the clock edge. Software can read the current vector back from an acknowledge register.

Top module: `irqc_top`

## Requirements
- R1: Pending bit n is loaded from `irq_in[n]` on every clock edge. It reads at 0x00 (sources 63..32) and at 0x04 (sources 31..0). Bus writes to 0x00 and 0x04 have no effect.
- R2: A source is active exactly when (pending OR force) AND enable AND NOT mask holds for it.
- R3: The active source with the largest priority byte wins. When priority bytes are equal, the higher-numbered source wins.
- R4: The internal active vector is the winner index plus 64, or 24 when no source is active. `irq_level` is bits [2:0] of the winner's priority byte, or 0 when no source is active. `irq_vector` equals the active vector while `irq_level` is nonzero and is 0 otherwise. Both outputs are registered, so they follow a register change one clock later and an input change two clocks later.
- R5: The priority byte of source n is at address 0x40+n and uses `bus_wdata[7:0]`. A write also sets the enable bit of that source when the value is nonzero and clears it when the value is zero. A read returns the byte zero-extended.
- R6: The mask reads and writes at 0x08 (sources 63..32) and at 0x0C (sources 31..0). Writing one half leaves the other half unchanged. A mask bit of 1 blocks its source.
- R7: A write to 0x18 sets mask bit `bus_wdata[5:0]`, and a write to 0x1C clears it. The upper data bits are ignored. Reads of these two addresses return 0.
- R8: The force register reads and writes at 0x10 (sources 63..32) and at 0x14 (sources 31..0). A set force bit acts on its source like a pending bit.
- R9: A read at 0xE0 returns the active vector, zero-extended. Writes to 0xE0 have no effect.
- R10: Synchronous active-high reset clears all priority bytes, pending, force and enable bits, sets every mask bit, sets the active vector to 24 and drives `irq_level` to 0.
- R11: A read at any other address returns 0. A write to any other address changes no state and raises `bus_err` for exactly the one clock after the write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| irq_in | input | 64 | Level-sensitive request inputs, one per source |
| bus_sel | input | 1 | Bus access strobe |
| bus_we | input | 1 | Write when high, read when low |
| bus_addr | input | 8 | Byte address within the window |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, combinational from address |
| bus_err | output | 1 | One-clock pulse after a write to an unmapped address |
| irq_level | output | 3 | Interrupt level to the processor |
| irq_vector | output | 8 | Vector number, 0 when the level is 0 |

## Verification
The assertions run on every clock and cover the following properties:
- A nonzero level always comes with a vector in the range 64 to 127.
- The idle vector 24 never comes with a nonzero level.
- A set-mask write always leaves the addressed mask bit at 1.
- A priority write always leaves the enable bit equal to whether the byte is nonzero.
- An unmapped write leaves the mask and force registers unchanged.

Other behaviours need the bench's scenarios, because they depend on particular register contents:
- Which source wins, including equal priorities and a priority byte whose low three bits are zero.
- The independence of the two mask halves.
- Forcing a source.
- The ignored pending writes.
- The reset values.

// File: rtl/irqc_pkg.sv
package irqc_pkg;
    localparam int NSRC   = 64;
    localparam int IDX_W  = $clog2(NSRC);
    localparam int HALF   = NSRC / 2;
    localparam int AW     = 8;
    localparam int DW     = 32;
    localparam int PW     = 8;
    localparam int LW     = 3;
    localparam int VW     = 8;
    localparam logic [VW-1:0] VEC_BASE = 8'd64;
    localparam logic [VW-1:0] VEC_IDLE = 8'd24;

    typedef enum logic [3:0] {
        REG_PEND_HI, REG_PEND_LO, REG_MASK_HI, REG_MASK_LO,
        REG_FRC_HI, REG_FRC_LO, REG_MSET, REG_MCLR,
        REG_PRIO, REG_ACK, REG_NONE
    } reg_sel_e;

    typedef struct packed {
        logic             found;
        logic [IDX_W-1:0] idx;
        logic [PW-1:0]    prio;
    } win_t;

    function automatic reg_sel_e decode_addr(input logic [AW-1:0] a);
        reg_sel_e r;
        if (a[7:6] == 2'b01) begin
            r = REG_PRIO;
        end else begin
            case (a)
                8'h00:   r = REG_PEND_HI;
                8'h04:   r = REG_PEND_LO;
                8'h08:   r = REG_MASK_HI;
                8'h0C:   r = REG_MASK_LO;
                8'h10:   r = REG_FRC_HI;
                8'h14:   r = REG_FRC_LO;
                8'h18:   r = REG_MSET;
                8'h1C:   r = REG_MCLR;
                8'hE0:   r = REG_ACK;
                default: r = REG_NONE;
            endcase
        end
        return r;
    endfunction

    function automatic logic [VW-1:0] vector_of(input win_t w);
        return w.found ? (VEC_BASE + {{(VW-IDX_W){1'b0}}, w.idx}) : VEC_IDLE;
    endfunction
endpackage

// File: rtl/irqc_regs.sv
module irqc_regs
    import irqc_pkg::*;
(
    input  logic                    clk,
    input  logic                    rst,
    input  logic [NSRC-1:0]         irq_in,
    input  logic                    bus_sel,
    input  logic                    bus_we,
    input  logic [AW-1:0]           bus_addr,
    input  logic [DW-1:0]           bus_wdata,
    input  logic [VW-1:0]           active_vec,
    output logic [DW-1:0]           bus_rdata,
    output logic                    bus_err,
    output logic [NSRC-1:0]         req,
    output logic [NSRC-1:0][PW-1:0] prio
);
    logic [NSRC-1:0] pend, mask, frc, en;
    reg_sel_e        dec;
    logic            wr;

    assign dec = decode_addr(bus_addr);
    assign wr  = bus_sel && bus_we;

    always_ff @(posedge clk) begin
        if (rst) begin
            pend    <= '0;
            mask    <= '1;
            frc     <= '0;
            en      <= '0;
            prio    <= '0;
            bus_err <= 1'b0;
        end else begin
            pend    <= irq_in;
            bus_err <= 1'b0;
            if (wr) begin
                case (dec)
                    REG_MASK_HI: mask[NSRC-1:HALF] <= bus_wdata;
                    REG_MASK_LO: mask[HALF-1:0]    <= bus_wdata;
                    REG_FRC_HI:  frc[NSRC-1:HALF]  <= bus_wdata;
                    REG_FRC_LO:  frc[HALF-1:0]     <= bus_wdata;
                    REG_MSET:    mask[bus_wdata[IDX_W-1:0]] <= 1'b1;
                    REG_MCLR:    mask[bus_wdata[IDX_W-1:0]] <= 1'b0;
                    REG_PRIO: begin
                        prio[bus_addr[IDX_W-1:0]] <= bus_wdata[PW-1:0];
                        en[bus_addr[IDX_W-1:0]]   <= |bus_wdata[PW-1:0];
                    end
                    REG_NONE:    bus_err <= 1'b1;
                    default: ;
                endcase
            end
        end
    end

    always_comb begin
        bus_rdata = '0;
        if (bus_sel && !bus_we) begin
            case (dec)
                REG_PEND_HI: bus_rdata = pend[NSRC-1:HALF];
                REG_PEND_LO: bus_rdata = pend[HALF-1:0];
                REG_MASK_HI: bus_rdata = mask[NSRC-1:HALF];
                REG_MASK_LO: bus_rdata = mask[HALF-1:0];
                REG_FRC_HI:  bus_rdata = frc[NSRC-1:HALF];
                REG_FRC_LO:  bus_rdata = frc[HALF-1:0];
                REG_PRIO:    bus_rdata = {{(DW-PW){1'b0}}, prio[bus_addr[IDX_W-1:0]]};
                REG_ACK:     bus_rdata = {{(DW-VW){1'b0}}, active_vec};
                default:     bus_rdata = '0;
            endcase
        end
    end

    genvar g;
    generate
        for (g = 0; g < NSRC; g++) begin : g_req
            assign req[g] = (pend[g] | frc[g]) & en[g] & ~mask[g];
        end
    endgenerate

    assert_mset_R7: assert property (@(posedge clk) disable iff (rst)
        (wr && dec == REG_MSET) |=> mask[$past(bus_wdata[IDX_W-1:0])]);

    assert_prio_en_R5: assert property (@(posedge clk) disable iff (rst)
        (wr && dec == REG_PRIO) |=>
        (en[$past(bus_addr[IDX_W-1:0])] == ($past(bus_wdata[PW-1:0]) != '0)));

    assert_err_nochange_R11: assert property (@(posedge clk) disable iff (rst)
        bus_err |-> ($stable(mask) && $stable(frc) && $stable(en)));
endmodule

// File: rtl/irqc_arbiter.sv
module irqc_arbiter
    import irqc_pkg::*;
(
    input  logic                    clk,
    input  logic                    rst,
    input  logic [NSRC-1:0]         req,
    input  logic [NSRC-1:0][PW-1:0] prio,
    output logic [LW-1:0]           level_q,
    output logic [VW-1:0]           vec_q
);
    win_t best;

    always_comb begin
        best = '0;
        for (int i = 0; i < NSRC; i++) begin
            if (req[i] && prio[i] >= best.prio) begin
                best.found = 1'b1;
                best.idx   = i[IDX_W-1:0];
                best.prio  = prio[i];
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            level_q <= '0;
            vec_q   <= VEC_IDLE;
        end else begin
            level_q <= best.found ? best.prio[LW-1:0] : '0;
            vec_q   <= vector_of(best);
        end
    end

    assert_vec_range_R4: assert property (@(posedge clk) disable iff (rst)
        (level_q != '0) |-> (vec_q >= VEC_BASE && vec_q < VEC_BASE + 8'(NSRC)));

    assert_idle_level_R4: assert property (@(posedge clk) disable iff (rst)
        (vec_q == VEC_IDLE) |-> (level_q == '0));
endmodule

// File: rtl/irqc_top.sv
module irqc_top
    import irqc_pkg::*;
(
    input  logic            clk,
    input  logic            rst,
    input  logic [63:0]     irq_in,
    input  logic            bus_sel,
    input  logic            bus_we,
    input  logic [7:0]      bus_addr,
    input  logic [31:0]     bus_wdata,
    output logic [31:0]     bus_rdata,
    output logic            bus_err,
    output logic [2:0]      irq_level,
    output logic [7:0]      irq_vector
);
    logic [NSRC-1:0]         req;
    logic [NSRC-1:0][PW-1:0] prio;
    logic [VW-1:0]           active_vec;

    irqc_regs u_regs (
        .clk        (clk),
        .rst        (rst),
        .irq_in     (irq_in),
        .bus_sel    (bus_sel),
        .bus_we     (bus_we),
        .bus_addr   (bus_addr),
        .bus_wdata  (bus_wdata),
        .active_vec (active_vec),
        .bus_rdata  (bus_rdata),
        .bus_err    (bus_err),
        .req        (req),
        .prio       (prio)
    );

    irqc_arbiter u_arb (
        .clk     (clk),
        .rst     (rst),
        .req     (req),
        .prio    (prio),
        .level_q (irq_level),
        .vec_q   (active_vec)
    );

    assign irq_vector = (irq_level != '0) ? active_vec : '0;
endmodule

// File: tb/irqc_top_test.sv
`timescale 1ns/1ps
module irqc_top_test;
    logic        clk = 0;
    logic        rst = 1;
    logic [63:0] irq_in = '0;
    logic        bus_sel = 0, bus_we = 0;
    logic [7:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        bus_err;
    logic [2:0]  irq_level;
    logic [7:0]  irq_vector;

    int checks = 0;
    int errors = 0;
    bit finished = 0;

    typedef struct {
        int          kind;
        logic [31:0] exp;
        string       tag;
    } item_t;
    item_t q[$];

    irqc_top uut (
        .clk(clk), .rst(rst), .irq_in(irq_in),
        .bus_sel(bus_sel), .bus_we(bus_we), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .bus_err(bus_err),
        .irq_level(irq_level), .irq_vector(irq_vector)
    );

    always #10 clk = ~clk;

    // Monitor: pops expected items and compares with what the design shows.
    always @(negedge clk) begin
        #2;
        while (q.size() > 0) begin
            item_t it;
            logic [31:0] act;
            it = q.pop_front();
            case (it.kind)
                0: act = bus_rdata;
                1: act = {29'd0, irq_level};
                2: act = {24'd0, irq_vector};
                default: act = {31'd0, bus_err};
            endcase
            checks++;
            if (act !== it.exp) begin
                errors++;
                $display("FAIL %s actual=%h expected=%h", it.tag, act, it.exp);
            end
        end
    end

    task automatic tick(input int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        @(posedge clk); #1;
        bus_sel = 1; bus_we = 1; bus_addr = a; bus_wdata = d;
        @(posedge clk); #1;
        bus_sel = 0; bus_we = 0;
    endtask

    task automatic chk_rd(input logic [7:0] a, input logic [31:0] e, input string tag);
        bus_sel = 1; bus_we = 0; bus_addr = a;
        q.push_back('{0, e, tag});
        @(posedge clk); #1;
        bus_sel = 0;
    endtask

    task automatic chk_out(input logic [2:0] lv, input logic [7:0] vec, input string tag);
        q.push_back('{1, {29'd0, lv}, tag});
        q.push_back('{2, {24'd0, vec}, tag});
        @(posedge clk); #1;
    endtask

    task automatic chk_err(input logic e, input string tag);
        q.push_back('{3, {31'd0, e}, tag});
        @(posedge clk); #1;
    endtask

    task automatic summary();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    endtask

    initial begin
        tick(3);
        rst = 0;
        tick(1);
        // R10 reset state
        chk_out(3'd0, 8'd0, "R10 outputs");
        chk_rd(8'hE0, 32'd24, "R10 R9 ack idle");
        chk_rd(8'h08, 32'hFFFF_FFFF, "R10 mask hi");
        chk_rd(8'h0C, 32'hFFFF_FFFF, "R10 mask lo");
        chk_rd(8'h45, 32'd0, "R10 prio");
        chk_rd(8'h04, 32'd0, "R10 pend");

        wr(8'h08, 32'd0);
        wr(8'h0C, 32'd0);
        wr(8'h45, 32'd3);
        irq_in[5] = 1;
        tick(2);
        chk_out(3'd3, 8'd69, "R2 R4 single source");
        chk_rd(8'hE0, 32'd69, "R9 ack");
        chk_rd(8'h04, 32'h20, "R1 pend lo");
        chk_rd(8'h45, 32'd3, "R5 prio readback");

        wr(8'h04, 32'd0);
        chk_rd(8'h04, 32'h20, "R1 pend write ignored");

        wr(8'h68, 32'd6);
        irq_in[40] = 1;
        tick(2);
        chk_out(3'd6, 8'd104, "R3 higher priority");
        chk_rd(8'h00, 32'h100, "R1 pend hi");

        wr(8'h72, 32'd6);
        wr(8'h10, 32'h0004_0000);
        tick(1);
        chk_out(3'd6, 8'd114, "R3 R8 tie to higher index via force");
        chk_rd(8'h10, 32'h0004_0000, "R8 force hi");

        wr(8'h18, 32'd50);
        tick(1);
        chk_out(3'd6, 8'd104, "R7 mask set");
        chk_rd(8'h08, 32'h0004_0000, "R7 mask hi after set");
        chk_rd(8'h18, 32'd0, "R7 set reads zero");

        wr(8'h1C, 32'hF2);
        tick(1);
        chk_out(3'd6, 8'd114, "R7 mask clear upper bits ignored");

        wr(8'h72, 32'd0);
        tick(1);
        chk_out(3'd6, 8'd104, "R5 R2 zero priority disables");
        chk_rd(8'h72, 32'd0, "R5 prio zero readback");

        wr(8'h08, 32'h100);
        tick(1);
        chk_out(3'd3, 8'd69, "R6 mask hi blocks source 40");
        chk_rd(8'h0C, 32'd0, "R6 mask lo untouched");

        wr(8'h47, 32'd8);
        irq_in[7] = 1;
        tick(2);
        chk_out(3'd0, 8'd0, "R4 zero level hides vector");
        chk_rd(8'hE0, 32'd71, "R4 R9 ack winner with level 0");

        wr(8'hE0, 32'd5);
        chk_err(1'b0, "R9 ack write no error");
        chk_rd(8'hE0, 32'd71, "R9 ack write ignored");

        wr(8'hF0, 32'hFFFF_FFFF);
        chk_err(1'b1, "R11 error pulse");
        chk_err(1'b0, "R11 error one cycle");
        chk_rd(8'hF0, 32'd0, "R11 unmapped read");
        chk_rd(8'h20, 32'd0, "R11 unmapped read 0x20");
        chk_rd(8'h0C, 32'd0, "R11 mask lo unchanged");
        chk_rd(8'h08, 32'h100, "R11 mask hi unchanged");

        irq_in = '0;
        wr(8'h10, 32'd0);
        tick(2);
        chk_out(3'd0, 8'd0, "R4 idle again");
        chk_rd(8'hE0, 32'd24, "R4 idle vector");

        tick(2);
        finished = 1;
        summary();
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=hung expected=done");
            summary();
        end
    end
endmodule